// File: doc/BRIEF.md
# Search Response Pipeline with External Table Strobes

This block sits on the response side of a search engine. The core hands it one request per clock: a lookup result, an engine read, a read of the external result table or a write to that table. The block moves each request through a fixed-length register pipeline. It then presents the request on a one-way index bus, together with the control pins that a synchronous pipelined SRAM needs. In this way the same index either goes back to the host as a search result or serves directly as the address of an external result table.

Read acknowledges come back a further fixed number of cycles later. That delay matches the read latency of the external memory. Because of it, an SRAM read issued in the middle of a request stream never holds up the requests behind it. Engine reads take the same delay, so the acknowledges stay in request order.

The pins go to a pad ring through a single drive-enable output. Reset, and a cleared enable bit, put every response pin in the undriven state. The enable bit is set or cleared only by a configuration write.

Top module: `rsp_driver`

## Requirements
- R1: While `rst` is high, and after it falls, `rspDrive` is 0 and every response output (`idxBus`, `ceOe`, `we`, `matchAck`, `lookupValid`, `readAck`) is 0. This holds until a configuration write sets the enable bit. Requests captured on a reset edge are dropped.
- R2: A clock edge with `cfgWe` high loads `cfgEnable` into the enable bit and `cfgIdxToSram` into the routing mode. From the next cycle on, `rspDrive` equals the enable bit. Whenever the enable bit is 0, all response outputs are forced to 0; requests still in the pipeline keep advancing.
- R3: A request sampled on clock edge k (`reqValid` high) shows on the outputs in the clock period that starts at edge k+PIPE_LAT-1. A new request is accepted on every edge. Responses leave in request order and never stall.
- R4: A lookup (`reqOp`=0) drives `idxBus`=`reqIdx`, `lookupValid`=1 and `matchAck`=`reqHit`. It drives `ceOe` equal to the routing mode that was in force when the request was sampled (1 = the index addresses the external table, 0 = the index goes to the host).
- R5: An SRAM read (`reqOp`=2) drives `idxBus`=`reqIdx`, `ceOe`=1 and `we`=0. SRAM_LAT cycles after its index appears, `readAck` pulses for one cycle.
- R6: An SRAM write (`reqOp`=3) drives `idxBus`=`reqIdx`, `ceOe`=1 and `we`=1, and produces no `readAck`. `we` is never high for any other operation.
- R7: An engine read (`reqOp`=1) leaves `idxBus`, `ceOe` and `we` at 0. It pulses `readAck` with the same total delay as an SRAM read, so read acknowledges keep request order.
- R8: `reqHit` has no effect on any operation other than a lookup. A cycle with `reqValid` low gives an all-zero response slot, whatever `reqOp`, `reqIdx` and `reqHit` carry.
- R9: `matchAck` high implies `lookupValid` high, and `we` high implies `ceOe` high. `lookupValid` and `we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change after its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgEnable | input | 1 | Enable bit value loaded on a configuration write |
| cfgIdxToSram | input | 1 | Routing mode loaded on a configuration write: lookups also strobe the SRAM |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | 0 lookup, 1 engine read, 2 SRAM read, 3 SRAM write |
| reqIdx | input | IDX_W | Lookup result index or SRAM address |
| reqHit | input | 1 | Lookup hit flag |
| idxBus | output | IDX_W | Index / SRAM address bus |
| ceOe | output | 1 | SRAM chip-enable / output-enable strobe |
| we | output | 1 | SRAM write-enable strobe |
| matchAck | output | 1 | Lookup hit flag returned with the index |
| lookupValid | output | 1 | Lookup completed, hit or miss |
| readAck | output | 1 | Read data (engine or SRAM) available |
| rspDrive | output | 1 | Drive enable for all response pins; 0 = high impedance |

## Verification
The bench builds the block with IDX_W=6, PIPE_LAT=2 and SRAM_LAT=3. With a 6-bit index, every index value can be swept under each of the four operations in both routing modes as one back-to-back stream. Because SRAM_LAT is larger than PIPE_LAT, read acknowledges are still in flight while later writes and lookups come out, so ordering is checked under overlap. The stream also runs through a disable window, idle slots carrying junk fields, and a reset in the middle of the run.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_ENGRD  = 2'd1,
    OP_SRAMRD = 2'd2,
    OP_SRAMWR = 2'd3
  } opKind_e;

  // Strobes handed from control to datapath for one response slot
  typedef struct packed {
    logic useIdx;
    logic ceOe;
    logic we;
    logic match;
    logic lkValid;
    logic rdAck;
  } strobe_t;
endpackage

// File: rtl/rsp_ctrl.sv
module rsp_ctrl
  import rsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgWe,
  input  logic       cfgEnable,
  input  logic       cfgIdxToSram,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       reqHit,
  output strobe_t    stb,
  output logic       enBit
);
  logic enReg;
  logic modeReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg   <= 1'b0;
      modeReg <= 1'b0;
    end else if (cfgWe) begin
      enReg   <= cfgEnable;
      modeReg <= cfgIdxToSram;
    end
  end

  always_comb begin
    stb = '0;
    if (reqValid) begin
      unique case (opKind_e'(reqOp))
        OP_LOOKUP: begin
          stb.useIdx  = 1'b1;
          stb.ceOe    = modeReg;
          stb.lkValid = 1'b1;
          stb.match   = reqHit;
        end
        OP_ENGRD: begin
          stb.rdAck = 1'b1;
        end
        OP_SRAMRD: begin
          stb.useIdx = 1'b1;
          stb.ceOe   = 1'b1;
          stb.rdAck  = 1'b1;
        end
        OP_SRAMWR: begin
          stb.useIdx = 1'b1;
          stb.ceOe   = 1'b1;
          stb.we     = 1'b1;
        end
        default: stb = '0;
      endcase
    end
  end

  assign enBit = enReg;
endmodule

// File: rtl/rsp_datapath.sv
module rsp_datapath
  import rsp_pkg::*;
#(
  parameter int IDX_W    = 15,
  parameter int PIPE_LAT = 2,
  parameter int SRAM_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stbIn,
  input  logic [IDX_W-1:0] idxIn,
  input  logic             enBit,
  output logic [IDX_W-1:0] idxOut,
  output logic             ceOe,
  output logic             we,
  output logic             matchAck,
  output logic             lookupValid,
  output logic             readAck,
  output logic             drive
);
  localparam int LAST = PIPE_LAT - 1;

  strobe_t          stStb [PIPE_LAT];
  logic [IDX_W-1:0] stIdx [PIPE_LAT];
  logic [SRAM_LAT-1:0] ackSh;

  for (genvar s = 0; s < PIPE_LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stStb[s] <= '0;
        stIdx[s] <= '0;
      end else if (s == 0) begin
        stStb[s] <= stbIn;
        stIdx[s] <= stbIn.useIdx ? idxIn : '0;
      end else begin
        stStb[s] <= stStb[(s == 0) ? 0 : s-1];
        stIdx[s] <= stIdx[(s == 0) ? 0 : s-1];
      end
    end
  end

  if (SRAM_LAT == 1) begin : g_ack1
    always_ff @(posedge clk) begin
      if (rst) ackSh <= '0;
      else     ackSh <= stStb[LAST].rdAck;
    end
  end else begin : g_ackN
    always_ff @(posedge clk) begin
      if (rst) ackSh <= '0;
      else     ackSh <= {ackSh[SRAM_LAT-2:0], stStb[LAST].rdAck};
    end
  end

  assign drive       = enBit;
  assign idxOut      = enBit ? stIdx[LAST] : '0;
  assign ceOe        = enBit & stStb[LAST].ceOe;
  assign we          = enBit & stStb[LAST].we;
  assign matchAck    = enBit & stStb[LAST].match;
  assign lookupValid = enBit & stStb[LAST].lkValid;
  assign readAck     = enBit & ackSh[SRAM_LAT-1];
endmodule

// File: rtl/rsp_driver.sv
module rsp_driver
  import rsp_pkg::*;
#(
  parameter int IDX_W    = 15,
  parameter int PIPE_LAT = 2,
  parameter int SRAM_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWe,
  input  logic             cfgEnable,
  input  logic             cfgIdxToSram,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic             reqHit,
  output logic [IDX_W-1:0] idxBus,
  output logic             ceOe,
  output logic             we,
  output logic             matchAck,
  output logic             lookupValid,
  output logic             readAck,
  output logic             rspDrive
);
  strobe_t stb;
  logic    enBit;

  rsp_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgEnable(cfgEnable),
    .cfgIdxToSram(cfgIdxToSram), .reqValid(reqValid), .reqOp(reqOp),
    .reqHit(reqHit), .stb(stb), .enBit(enBit)
  );

  rsp_datapath #(.IDX_W(IDX_W), .PIPE_LAT(PIPE_LAT), .SRAM_LAT(SRAM_LAT)) u_dp (
    .clk(clk), .rst(rst), .stbIn(stb), .idxIn(reqIdx), .enBit(enBit),
    .idxOut(idxBus), .ceOe(ceOe), .we(we), .matchAck(matchAck),
    .lookupValid(lookupValid), .readAck(readAck), .drive(rspDrive)
  );
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
  parameter int IDX_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             cfgWe,
  input logic [IDX_W-1:0] idxBus,
  input logic             ceOe,
  input logic             we,
  input logic             matchAck,
  input logic             lookupValid,
  input logic             readAck,
  input logic             rspDrive
);
  AST_RESET_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rspDrive); // R1

  AST_OFF_PINS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rspDrive |-> (idxBus == '0 && !ceOe && !we && !matchAck && !lookupValid && !readAck)); // R2

  AST_DRIVE_ONLY_BY_CFG: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfgWe) && !$past(rst)) |-> $stable(rspDrive)); // R2

  AST_WE_WITH_CE: assert property (@(posedge clk) disable iff (rst)
    we |-> ceOe); // R6

  AST_MATCH_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    matchAck |-> lookupValid); // R9

  AST_LOOKUP_NOT_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lookupValid, we})); // R9
endmodule

bind rsp_driver rsp_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cfgWe(cfgWe), .idxBus(idxBus), .ceOe(ceOe), .we(we),
  .matchAck(matchAck), .lookupValid(lookupValid), .readAck(readAck),
  .rspDrive(rspDrive)
);

// File: tb/tb_rsp_driver.sv
module tb_rsp_driver;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 6;
  localparam int PIPE = 2;
  localparam int SLAT = 3;
  localparam int N = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWe = 1'b0, cfgEnable = 1'b0, cfgIdxToSram = 1'b0;
  logic reqValid = 1'b0, reqHit = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [IDX_W-1:0] reqIdx = '0;
  logic [IDX_W-1:0] idxBus;
  logic ceOe, we, matchAck, lookupValid, readAck, rspDrive;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsp_driver #(.IDX_W(IDX_W), .PIPE_LAT(PIPE), .SRAM_LAT(SLAT)) dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgEnable(cfgEnable),
    .cfgIdxToSram(cfgIdxToSram), .reqValid(reqValid), .reqOp(reqOp),
    .reqIdx(reqIdx), .reqHit(reqHit), .idxBus(idxBus), .ceOe(ceOe), .we(we),
    .matchAck(matchAck), .lookupValid(lookupValid), .readAck(readAck),
    .rspDrive(rspDrive)
  );

  // per-edge history of what the bench applied
  logic             qVal  [N];
  logic [1:0]       qOp   [N];
  logic [IDX_W-1:0] qIdx  [N];
  logic             qHit  [N];
  logic             qMode [N];
  logic             enA   [N];
  logic modelEn = 1'b0, modelMode = 1'b0;
  int cyc = 0;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic checkNow();
    int k, j;
    logic v, en, rdv;
    logic [1:0] op;
    int eIdx, eCe, eWe, eLv, eMt, eRd;
    string tCe, tMt, tRd;
    en = (cyc >= 1) ? enA[cyc-1] : 1'b0;
    k = cyc - PIPE;
    v = (k >= 0) ? qVal[k] : 1'b0;
    op = (k >= 0) ? qOp[k] : 2'd0;
    eIdx = (v && op != 2'd1) ? int'(qIdx[k]) : 0;
    eCe = (v && (op == 2'd2 || op == 2'd3 || (op == 2'd0 && qMode[k]))) ? 1 : 0;
    eWe = (v && op == 2'd3) ? 1 : 0;
    eLv = (v && op == 2'd0) ? 1 : 0;
    eMt = (eLv == 1 && qHit[k]) ? 1 : 0;
    j = cyc - PIPE - SLAT;
    rdv = (j >= 0) ? (qVal[j] && (qOp[j] == 2'd1 || qOp[j] == 2'd2)) : 1'b0;
    eRd = rdv ? 1 : 0;
    if (!en) begin
      eIdx = 0; eCe = 0; eWe = 0; eLv = 0; eMt = 0; eRd = 0;
    end
    tCe = (op == 2'd0) ? "R4" : (op == 2'd3 ? "R6" : "R5");
    tMt = (op == 2'd0) ? "R4" : "R8";
    tRd = (j >= 0 && qOp[j] == 2'd1) ? "R7" : "R5";
    chk(rst ? "R1" : "R2", "rspDrive", int'(rspDrive), int'(en));
    chk("R3", "idxBus", int'(idxBus), eIdx);
    chk(tCe, "ceOe", int'(ceOe), eCe);
    chk("R6", "we", int'(we), eWe);
    chk("R4", "lookupValid", int'(lookupValid), eLv);
    chk(tMt, "matchAck", int'(matchAck), eMt);
    chk(tRd, "readAck", int'(readAck), eRd);
    chk("R9", "we without ceOe", int'(we & ~ceOe), 0);
  endtask

  // one clock: check outputs for this period, then apply the next inputs
  task automatic step(input logic r, input logic cw, input logic ce, input logic cm,
                      input logic v, input logic [1:0] op, input logic [IDX_W-1:0] idx,
                      input logic h);
    @(negedge clk);
    checkNow();
    if (rst) begin
      chk("R1", "idle outputs in reset", int'(idxBus) + int'(ceOe) + int'(we) +
          int'(matchAck) + int'(lookupValid) + int'(readAck), 0);
    end
    rst = r; cfgWe = cw; cfgEnable = ce; cfgIdxToSram = cm;
    reqValid = v; reqOp = op; reqIdx = idx; reqHit = h;
    qVal[cyc] = v && !r; qOp[cyc] = op; qIdx[cyc] = idx; qHit[cyc] = h;
    qMode[cyc] = modelMode;
    if (r) begin
      modelEn = 1'b0; modelMode = 1'b0;
    end else if (cw) begin
      modelEn = ce; modelMode = cm;
    end
    enA[cyc] = modelEn;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, 1'b0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      qVal[i] = 0; qOp[i] = 0; qIdx[i] = 0; qHit[i] = 0; qMode[i] = 0; enA[i] = 0;
    end
    // R1: reset, then stay quiet after release
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 6'h2a, 1'b1);
    idle(4);
    // R2: requests while disabled give nothing on the pins
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'(i), 6'(i * 5), 1'b1);
    idle(6);
    // R3..R8: every op, every index, both routing modes, back to back
    for (int m = 0; m < 2; m++) begin
      step(1'b0, 1'b1, 1'b1, 1'(m), 1'b0, 2'd0, '0, 1'b0);
      for (int op = 0; op < 4; op++) begin
        for (int ix = 0; ix < 64; ix++) begin
          step(1'b0, 1'b0, 1'b0, 1'b0, (ix % 7) != 3, 2'(op), 6'(ix),
               (^6'(ix)) ^ op[0]);
        end
      end
    end
    // R5/R7/R6 interleaved: reads between writes and lookups
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'((i * 3) % 4), 6'(63 - i), i[1]);
    // R2: disable mid-stream, then enable again, with mode switch
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 6'h11, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'(i % 4), 6'(i + 20), 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 6'h3f, 1'b1);
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'(i % 4), 6'(i * 4), ~i[0]);
    idle(10);
    // R1: reset in the middle of a run
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 6'h05, 1'b0);
    idle(6);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, '0, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'(i % 4), 6'(i + 50), i[0]);
    idle(8);
    finish();
  end
endmodule